// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Controller

This block sits between a simple one-command-per-cycle user port and a synchronous SRAM that needs no dead cycle when the bus changes direction. In every cycle the user may present a read, a write or nothing. An accepted command reaches the SRAM address and strobe pins in the next cycle. Write data is held back by the device latency, so it lands on the shared data bus in the slot the memory expects for that write. Read data is captured when the memory returns it, and it comes back to the user with a valid flag and the tag that was given with the command.

A build-time switch selects the device timing. With pipelined timing, the read data and the delayed write data occupy the bus two cycles after the command. With flow-through timing they occupy it one cycle after. A read can also ask for a burst of four words. The controller then issues the following three addresses on its own, with the address wrapping at the top of the address space. While it does so, it holds the user port off with a ready signal. The bidirectional data bus is brought out as separate out, out-enable and in signals.

Top module: `zbt_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it: sram_en_n=1, sram_we_n=1, sram_dq_oe=0, rd_valid=0, cmd_ready=1.
- R2: A command accepted at a clock edge (cmd_valid=1, cmd_ready=1) appears on the SRAM pins in the following cycle. In that cycle sram_en_n=0 and sram_addr=cmd_addr. sram_we_n=0 for a write (cmd_write=1) and sram_we_n=1 for a read. Reads and writes in any mix follow each other in consecutive cycles with no idle cycle between them.
- R3: An edge with cmd_ready=1 and cmd_valid=0 gives an idle cycle on the pins: sram_en_n=1 and sram_we_n=1.
- R4: sram_dq_oe is 1 exactly LAT cycles after a write cycle on the pins, and sram_dq_out then carries that write's data. LAT=2 for pipelined timing (PIPELINED=1) and LAT=1 for flow-through timing (PIPELINED=0). In every other cycle sram_dq_oe is 0.
- R5: sram_dq_in is sampled in the cycle LAT cycles after a read cycle on the pins. It is presented on rd_data one cycle later, together with rd_valid=1 and that command's tag. Words come back in issue order, and no rd_valid appears without a read.
- R6: A read accepted with cmd_burst=1 puts addresses base, base+1, base+2 and base+3 (modulo 2^ADDR_W) on the pins in four consecutive read cycles. All four words are returned under the same tag.
- R7: After a burst read is accepted, cmd_ready is 0 for the three following cycles and 1 again afterwards. Any command presented while cmd_ready is 0 is ignored: it changes neither the pins nor the memory contents.
- R8: cmd_burst has no effect on a write. The write issues one cycle, and cmd_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_burst | input | 1 | Read of BURST_LEN consecutive words |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Write data |
| cmd_tag | input | TAG_W | Tag returned with read data |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| sram_en_n | output | 1 | Active-low cycle enable to the SRAM |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_addr | output | ADDR_W | SRAM address |
| sram_dq_out | output | DATA_W | Data driven toward the SRAM |
| sram_dq_oe | output | 1 | Output enable of the data bus |
| sram_dq_in | input | DATA_W | Data received from the SRAM |
| rd_valid | output | 1 | Returned read word is valid |
| rd_data | output | DATA_W | Returned read word |
| rd_tag | output | TAG_W | Tag of the returned word |

## Verification
The case hardest to reach is a read issued in the cycle right after a write to the same address. Here the delayed write data and the read return meet within one or two cycles. A wrong depth in either delay line returns stale data or drives the bus in the wrong slot. The stimulus places write-then-read pairs back to back on the same word, and it runs a long alternating read/write stream. Two instances, one for each timing variant, share the same commands, each with its own behavioural memory. The bench also keeps presenting writes to a marker address during a burst, and later reads that address back to show that the writes were dropped.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

   typedef enum logic [1:0] {
      ZOP_IDLE  = 2'd0,
      ZOP_READ  = 2'd1,
      ZOP_WRITE = 2'd2
   } zbt_op_e;

   // cycles between the command on the pins and its data on the bus
   function automatic int bus_latency(input int pipelined);
      return (pipelined != 0) ? 2 : 1;
   endfunction

endpackage

// File: rtl/zbt_delay.sv
module zbt_delay #(
   parameter int W     = 8,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("zbt_delay: DEPTH must be at least 1");
   end

   logic [W-1:0] stg [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar i = 1; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stg[i] <= '0;
         else        stg[i] <= stg[i-1];
      end
   end

   assign q = stg[DEPTH-1];

endmodule

// File: rtl/zbt_issue.sv
module zbt_issue
   import zbt_pkg::*;
#(
   parameter int ADDR_W    = 18,
   parameter int DATA_W    = 36,
   parameter int TAG_W     = 4,
   parameter int BURST_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_write,
   input  logic              cmd_burst,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic [TAG_W-1:0]  cmd_tag,
   output logic              cmd_ready,
   output zbt_op_e           iss_op,
   output logic [ADDR_W-1:0] iss_addr,
   output logic [DATA_W-1:0] iss_wdata,
   output logic [TAG_W-1:0]  iss_tag
);

   localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

   logic [CNT_W-1:0] burst_left;

   assign cmd_ready = (burst_left == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         iss_op     <= ZOP_IDLE;
         iss_addr   <= '0;
         iss_wdata  <= '0;
         iss_tag    <= '0;
         burst_left <= '0;
      end else if (burst_left != '0) begin
         // continue the burst from the last issued address
         iss_op     <= ZOP_READ;
         iss_addr   <= iss_addr + ADDR_W'(1);
         burst_left <= burst_left - CNT_W'(1);
      end else if (cmd_valid) begin
         iss_op    <= cmd_write ? ZOP_WRITE : ZOP_READ;
         iss_addr  <= cmd_addr;
         iss_wdata <= cmd_wdata;
         iss_tag   <= cmd_tag;
         if (!cmd_write && cmd_burst)
            burst_left <= CNT_W'(BURST_LEN - 1);
      end else begin
         iss_op <= ZOP_IDLE;
      end
   end

endmodule

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
   import zbt_pkg::*;
#(
   parameter int ADDR_W    = 18,
   parameter int DATA_W    = 36,
   parameter int TAG_W     = 4,
   parameter int BURST_LEN = 4,
   parameter int PIPELINED = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_write,
   input  logic              cmd_burst,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic [TAG_W-1:0]  cmd_tag,
   output logic              cmd_ready,
   output logic              sram_en_n,
   output logic              sram_we_n,
   output logic [ADDR_W-1:0] sram_addr,
   output logic [DATA_W-1:0] sram_dq_out,
   output logic              sram_dq_oe,
   input  logic [DATA_W-1:0] sram_dq_in,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [TAG_W-1:0]  rd_tag
);

   localparam int LAT    = bus_latency(PIPELINED);
   localparam int SLOT_W = 2 + TAG_W + DATA_W;

   if (PIPELINED != 0 && PIPELINED != 1) begin : g_bad_mode
      $error("zbt_ctrl: PIPELINED must be 0 or 1");
   end
   if (BURST_LEN < 2) begin : g_bad_burst
      $error("zbt_ctrl: BURST_LEN must be at least 2");
   end
   if (ADDR_W < 2 || DATA_W < 1 || TAG_W < 1) begin : g_bad_width
      $error("zbt_ctrl: widths out of range");
   end

   zbt_op_e           iss_op;
   logic [DATA_W-1:0] iss_wdata;
   logic [TAG_W-1:0]  iss_tag;

   zbt_issue #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .BURST_LEN(BURST_LEN)
   ) u_issue (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_burst(cmd_burst),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_tag(cmd_tag),
      .cmd_ready(cmd_ready),
      .iss_op(iss_op), .iss_addr(sram_addr), .iss_wdata(iss_wdata), .iss_tag(iss_tag)
   );

   assign sram_en_n = (iss_op == ZOP_IDLE);
   assign sram_we_n = (iss_op != ZOP_WRITE);

   // write enable, read flag, tag and write data travel together to the bus slot
   logic [SLOT_W-1:0] slot_d, slot_q;
   assign slot_d = {iss_op == ZOP_WRITE, iss_op == ZOP_READ, iss_tag, iss_wdata};

   zbt_delay #(.W(SLOT_W), .DEPTH(LAT)) u_slot (
      .clk(clk), .rst_n(rst_n), .d(slot_d), .q(slot_q)
   );

   logic              slot_wr, slot_rd;
   logic [TAG_W-1:0]  slot_tag;
   assign slot_wr  = slot_q[SLOT_W-1];
   assign slot_rd  = slot_q[SLOT_W-2];
   assign slot_tag = slot_q[DATA_W +: TAG_W];

   assign sram_dq_oe  = slot_wr;
   assign sram_dq_out = slot_q[DATA_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         rd_tag   <= '0;
      end else begin
         rd_valid <= slot_rd;
         if (slot_rd) begin
            rd_data <= sram_dq_in;
            rd_tag  <= slot_tag;
         end
      end
   end

endmodule

// File: rtl/zbt_ctrl_chk.sv
module zbt_ctrl_chk #(
   parameter int ADDR_W    = 18,
   parameter int PIPELINED = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_write,
   input logic              cmd_burst,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic              cmd_ready,
   input logic              sram_en_n,
   input logic              sram_we_n,
   input logic [ADDR_W-1:0] sram_addr,
   input logic              sram_dq_oe,
   input logic              rd_valid
);

   // R2
   accept_to_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> (!sram_en_n && (sram_we_n == $past(!cmd_write))
                                    && (sram_addr == $past(cmd_addr))));

   // R3
   idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ready && !cmd_valid) |=> (sram_en_n && sram_we_n));

   // R6
   burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_ready |=> (!sram_en_n && sram_we_n && (sram_addr == $past(sram_addr) + 1'b1)));

   // R7
   burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_burst && !cmd_write) |=> !cmd_ready);

   // R8
   write_no_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_burst && cmd_write) |=> cmd_ready);

   if (PIPELINED != 0) begin : g_pl
      // R4
      write_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!sram_en_n && !sram_we_n) |-> ##2 sram_dq_oe);
      // R4
      oe_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
         sram_dq_oe |-> $past(!sram_en_n && !sram_we_n, 2));
      // R5
      rd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rd_valid |-> $past(!sram_en_n && sram_we_n, 3));
   end else begin : g_ft
      // R4
      write_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!sram_en_n && !sram_we_n) |=> sram_dq_oe);
      // R4
      oe_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
         sram_dq_oe |-> $past(!sram_en_n && !sram_we_n, 1));
      // R5
      rd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rd_valid |-> $past(!sram_en_n && sram_we_n, 2));
   end

endmodule

bind zbt_ctrl zbt_ctrl_chk #(.ADDR_W(ADDR_W), .PIPELINED(PIPELINED)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
   .cmd_burst(cmd_burst), .cmd_addr(cmd_addr), .cmd_ready(cmd_ready),
   .sram_en_n(sram_en_n), .sram_we_n(sram_we_n), .sram_addr(sram_addr),
   .sram_dq_oe(sram_dq_oe), .rd_valid(rd_valid)
);

// File: tb/zbt_ctrl_bench.sv
`timescale 1ns/1ps

module zbt_sram_model #(
   parameter int AW  = 8,
   parameter int DW  = 16,
   parameter int LAT = 2
) (
   input  logic          clk,
   input  logic          en_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] dq_out,
   output logic [DW-1:0] dq_in
);
   logic [DW-1:0] mem [2**AW];
   logic          h_rd   [LAT];
   logic          h_wr   [LAT];
   logic [AW-1:0] h_addr [LAT];

   initial begin
      for (int i = 0; i < 2**AW; i++) mem[i] = DW'(i * 257) ^ DW'(16'h5A3C);
      for (int i = 0; i < LAT; i++) begin h_rd[i] = 0; h_wr[i] = 0; h_addr[i] = '0; end
   end

   always @(posedge clk) begin
      if (h_wr[LAT-1]) mem[h_addr[LAT-1]] <= dq_out;
      for (int i = LAT-1; i > 0; i--) begin
         h_rd[i] <= h_rd[i-1]; h_wr[i] <= h_wr[i-1]; h_addr[i] <= h_addr[i-1];
      end
      h_rd[0]   <= !en_n && we_n;
      h_wr[0]   <= !en_n && !we_n;
      h_addr[0] <= addr;
   end

   assign dq_in = h_rd[LAT-1] ? mem[h_addr[LAT-1]] : '0;
endmodule

module zbt_ctrl_bench;
   localparam int AW = 8, DW = 16, TW = 4;

   typedef struct { int cyc; logic [DW-1:0] data; logic [TW-1:0] tag; } rd_exp_t;
   typedef struct { int cyc; logic [DW-1:0] data; } wr_exp_t;

   logic clk = 0, rst_n = 0;
   always #2.5 clk = ~clk;

   logic          cmd_valid = 0, cmd_write = 0, cmd_burst = 0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_wdata = '0;
   logic [TW-1:0] cmd_tag = '0;

   logic          rdy_p, en_p, we_p, oe_p, rdv_p, rdy_f, en_f, we_f, oe_f, rdv_f;
   logic [AW-1:0] addr_p, addr_f;
   logic [DW-1:0] dqo_p, dqi_p, rdd_p, dqo_f, dqi_f, rdd_f;
   logic [TW-1:0] tag_p, tag_f;

   zbt_ctrl #(.ADDR_W(AW), .DATA_W(DW), .TAG_W(TW), .BURST_LEN(4), .PIPELINED(1)) u_zbt_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_burst(cmd_burst), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_tag(cmd_tag),
      .cmd_ready(rdy_p), .sram_en_n(en_p), .sram_we_n(we_p), .sram_addr(addr_p),
      .sram_dq_out(dqo_p), .sram_dq_oe(oe_p), .sram_dq_in(dqi_p),
      .rd_valid(rdv_p), .rd_data(rdd_p), .rd_tag(tag_p));

   zbt_ctrl #(.ADDR_W(AW), .DATA_W(DW), .TAG_W(TW), .BURST_LEN(4), .PIPELINED(0)) u_zbt_ctrl_ft (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_burst(cmd_burst), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_tag(cmd_tag),
      .cmd_ready(rdy_f), .sram_en_n(en_f), .sram_we_n(we_f), .sram_addr(addr_f),
      .sram_dq_out(dqo_f), .sram_dq_oe(oe_f), .sram_dq_in(dqi_f),
      .rd_valid(rdv_f), .rd_data(rdd_f), .rd_tag(tag_f));

   zbt_sram_model #(.AW(AW), .DW(DW), .LAT(2)) u_mem_p (
      .clk(clk), .en_n(en_p), .we_n(we_p), .addr(addr_p), .dq_out(dqo_p), .dq_in(dqi_p));
   zbt_sram_model #(.AW(AW), .DW(DW), .LAT(1)) u_mem_f (
      .clk(clk), .en_n(en_f), .we_n(we_f), .addr(addr_f), .dq_out(dqo_f), .dq_in(dqi_f));

   int n_chk = 0, n_err = 0, cyc = 0;
   bit run = 0, done = 0;
   logic [DW-1:0] shadow [2**AW];
   rd_exp_t rq_p[$], rq_f[$];
   wr_exp_t wq_p[$], wq_f[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // scoreboard monitors, one per timing variant
   always @(negedge clk) begin
      if (run) begin
         bit eo;
         rd_exp_t e;
         eo = (wq_p.size() > 0) && (wq_p[0].cyc == cyc);
         chk("R4 pipelined oe slot", oe_p, eo);
         if (eo) begin chk("R4 pipelined write data", dqo_p, wq_p[0].data); void'(wq_p.pop_front()); end
         if (rdv_p) begin
            if (rq_p.size() == 0) chk("R5 pipelined spurious rd_valid", 1, 0);
            else begin
               e = rq_p.pop_front();
               chk("R5 pipelined return cycle", cyc, e.cyc);
               chk("R5/R6 pipelined data", rdd_p, e.data);
               chk("R5/R6 pipelined tag", tag_p, e.tag);
            end
         end
         eo = (wq_f.size() > 0) && (wq_f[0].cyc == cyc);
         chk("R4 flow-through oe slot", oe_f, eo);
         if (eo) begin chk("R4 flow-through write data", dqo_f, wq_f[0].data); void'(wq_f.pop_front()); end
         if (rdv_f) begin
            if (rq_f.size() == 0) chk("R5 flow-through spurious rd_valid", 1, 0);
            else begin
               e = rq_f.pop_front();
               chk("R5 flow-through return cycle", cyc, e.cyc);
               chk("R5/R6 flow-through data", rdd_f, e.data);
               chk("R5/R6 flow-through tag", tag_f, e.tag);
            end
         end
      end
   end

   // driver: called at a negedge, returns at the negedge after the command is on the pins
   task automatic issue(input bit w, input bit b, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [TW-1:0] t);
      int c;
      cmd_valid = 1; cmd_write = w; cmd_burst = b; cmd_addr = a; cmd_wdata = d; cmd_tag = t;
      @(posedge clk); @(negedge clk);
      c = cyc;
      chk("R2 en_n", en_p, 0);
      chk("R2 we_n", we_p, !w);
      chk("R2 address", addr_p, a);
      chk("R2 flow-through address", addr_f, a);
      if (w) begin
         shadow[a] = d;
         wq_p.push_back('{c + 2, d});
         wq_f.push_back('{c + 1, d});
         if (b) chk("R8 ready after write with burst flag", rdy_p, 1);
      end else begin
         for (int k = 0; k < (b ? 4 : 1); k++) begin
            rq_p.push_back('{c + 3 + k, shadow[AW'(a + k)], t});
            rq_f.push_back('{c + 2 + k, shadow[AW'(a + k)], t});
         end
         if (b) begin
            chk("R7 ready low after burst", rdy_p, 0);
            cmd_write = 1; cmd_burst = 0; cmd_addr = 8'h77; cmd_wdata = 16'hDEAD;
            for (int k = 1; k < 4; k++) begin
               @(posedge clk); @(negedge clk);
               chk("R6 burst address", addr_p, AW'(a + k));
               chk("R6 burst is read", {en_p, we_p}, 2'b01);
               chk("R7 ready during burst", rdy_p, (k == 3));
               if (k == 3) cmd_valid = 0;
            end
         end
      end
   endtask

   task automatic idle();
      cmd_valid = 0;
      @(posedge clk); @(negedge clk);
      chk("R3 idle pins", {en_p, we_p}, 2'b11);
   endtask

   initial begin
      for (int i = 0; i < 2**AW; i++) shadow[i] = DW'(i * 257) ^ DW'(16'h5A3C);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset en_n/we_n", {en_p, we_p}, 2'b11);
      chk("R1 reset oe", oe_p, 0);
      chk("R1 reset rd_valid", rdv_p, 0);
      chk("R1 reset ready", rdy_p, 1);
      rst_n = 1;
      run = 1;
      @(negedge clk);
      chk("R1 first cycle after reset", {en_p, we_p, oe_p, rdy_f}, 4'b1101);
      // back-to-back writes, then reads, then read right after a write to the same word
      for (int i = 0; i < 4; i++) issue(1, 0, AW'(10 + i), DW'(16'h1000 + i), 0);
      issue(0, 0, 10, 0, 1);
      issue(0, 0, 11, 0, 2);
      issue(1, 0, 11, 16'hBEEF, 0);
      issue(0, 0, 11, 0, 3);
      idle();
      // bursts: plain and wrapping at the top of the address space
      issue(0, 1, 12, 0, 4);
      issue(0, 1, 8'hFE, 0, 5);
      issue(1, 0, 8'hFF, 16'h7777, 0);
      issue(0, 1, 8'hFD, 0, 6);
      // write with the burst flag, and the ignored marker write
      issue(1, 1, 20, 16'h2020, 0);
      issue(0, 0, 20, 0, 7);
      issue(0, 0, 21, 0, 8);
      issue(0, 0, 8'h77, 0, 9);
      idle();
      // alternating read/write stream at full bus use
      for (int i = 0; i < 24; i++) begin
         if (i % 2 == 0) issue(1, 0, AW'(40 + i / 2), DW'(i * 99 + 3), 0);
         else            issue(0, 0, AW'(40 + i / 2), 0, TW'(i));
      end
      repeat (8) idle();
      chk("R5 pipelined reads drained", rq_p.size(), 0);
      chk("R5 flow-through reads drained", rq_f.size(), 0);
      chk("R4 writes drained", wq_p.size() + wq_f.size(), 0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule